// File: doc/BRIEF.md
# Serial Wire Debug Host Write Engine

This block is the host side of a two-wire serial debug link, restricted to single register writes. When it accepts a start strobe it latches the target select (debug port or access port), a two-bit register address and a data word. It then runs one complete write transaction on the clock and data pins: a request header built from fields, a turnaround, a three-bit acknowledge from the target, a second turnaround, the data word and its parity bit. When the transaction ends it pulses `done` and holds the acknowledge it received on `ack`.

The serial clock comes from the system clock through a programmable divider. Each bit slot is a low half followed by a high half, and each half lasts `half_div + 1` system cycles. The host changes its data pin only when the serial clock goes low. The target samples on the rising edge, and the host samples the acknowledge on the rising edge.

The controller has eight named states. `S_IDLE` goes to `S_REQ` on start. `S_REQ` goes to `S_TRN1` after eight header slots. `S_TRN1` goes to `S_ACK` after one slot. `S_ACK` goes to `S_TRN2` after three slots if the acknowledge is OK, and to `S_FIN` otherwise. `S_TRN2` goes to `S_DATA` after one slot. `S_DATA` goes to `S_PAR` after the data slots. `S_PAR` goes to `S_FIN` after one slot. `S_FIN` goes back to `S_IDLE` unconditionally.

Top module: `swd_wr_engine`

## Requirements
- R1: After reset, `swclk`, `swdio_oe`, `swdio_o`, `busy` and `done` are 0 and `ack` is 3'b000.
- R2: The request header is eight slots. In transmission order the bits are: 1, port select (0 = debug port, 1 = access port), 0 (write), address bit 0, address bit 1, parity, 0, 1. A debug-port write with address field 2'b01 therefore sends 1,0,0,1,0,1,0,1.
- R3: The header parity bit is the XOR of the port select, the write bit and both address bits.
- R4: `swclk` is low while idle. In each slot it is low for `half_div+1` system cycles and then high for `half_div+1` cycles. The first rising edge comes `half_div+1` cycles after the start strobe is accepted.
- R5: `swdio_o` and `swdio_oe` do not change while `swclk` stays high.
- R6: `swdio_oe` is 0 in the slot after the header, in the three acknowledge slots and in the slot after the acknowledge.
- R7: The acknowledge is sampled on three rising edges, first bit into `ack[0]`, and is presented on `ack` when `done` pulses.
- R8: When `ack` is 3'b001, 32 data slots follow, least significant bit first, and then one slot carrying the XOR of all data bits. The whole transaction is 46 slots.
- R9: For any other acknowledge value the data phase is skipped. The transaction ends after 12 slots and `swdio_oe` is not raised again.
- R10: `done` is a single-cycle pulse. `busy` is high from the accepted start until `done`. A start strobe while busy is ignored and does not begin another transaction.
- R11: Port select, address, data and divider are captured at start. Changing them while busy has no effect on the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a write transaction when idle |
| ap_sel | input | 1 | 0 selects debug port, 1 access port |
| addr | input | 2 | Register address bits [3:2] |
| wdata | input | 32 | Data word to write |
| half_div | input | 8 | Half serial-clock period minus one, in system cycles |
| swclk | output | 1 | Serial debug clock |
| swdio_o | output | 1 | Serial data driven by host |
| swdio_oe | output | 1 | Host output enable for serial data |
| swdio_i | input | 1 | Serial data from the pin |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| ack | output | 3 | Acknowledge received from target |

## Verification
Some properties are checked by assertions on every cycle: the data pin and its enable stay frozen while the serial clock is high, the clock is held low whenever the engine is idle, `done` never lasts two cycles, and the data phase is reached only with an OK acknowledge. Other behaviour can only be shown by the bench scenarios, acting as a target model. These are the header bit order and parity for every port and address combination, the data word and its parity, the exact slot count and clock half-periods across divider settings, the treatment of each of the eight acknowledge codes, and the fact that input changes and start strobes made mid-transaction have no effect.

// File: rtl/swd_wr_pkg.sv
package swd_wr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_TRN1,
        S_ACK,
        S_TRN2,
        S_DATA,
        S_PAR,
        S_FIN
    } swd_state_e;

    localparam logic [2:0] ACK_OK  = 3'b001;
    localparam int         HDR_LEN = 8;
    localparam int         ACK_LEN = 3;
endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             swclk,
    output logic             rise_ev,
    output logic             slot_end
);
    logic [DIV_W-1:0] cnt;
    logic             ph;
    logic             wrap;

    assign wrap = (cnt == half);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (!en) begin
            cnt <= '0;
            ph  <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            ph  <= ~ph;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign swclk    = ph;
    assign rise_ev  = en && !ph && wrap;
    assign slot_end = en && ph && wrap;

    // R4: a disabled generator parks the clock low
    a_r4_park_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !swclk);
endmodule

// File: rtl/swd_req_hdr.sv
module swd_req_hdr (
    input  logic       ap_sel,
    input  logic [1:0] addr,
    output logic [7:0] hdr
);
    logic rnw;
    logic par;

    assign rnw = 1'b0;
    // R3: even parity over the four request fields
    assign par = ap_sel ^ rnw ^ addr[0] ^ addr[1];

    // R2: bit 0 goes on the wire first
    assign hdr = {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap_sel, 1'b1};
endmodule

// File: rtl/swd_wr_engine.sv
module swd_wr_engine
    import swd_wr_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ap_sel,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  half_div,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i,
    output logic              busy,
    output logic              done,
    output logic [2:0]        ack
);
    localparam int IDX_W = ($clog2(DATA_W) > 3) ? $clog2(DATA_W) : 3;
    localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] ACK_LAST  = IDX_W'(ACK_LEN - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_W - 1);

    swd_state_e        state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic              ap_q;
    logic [1:0]        addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DIV_W-1:0]  half_q;
    logic [2:0]        ack_q;
    logic [7:0]        hdr;
    logic              clk_en;
    logic              rise_ev;
    logic              slot_end;

    swd_req_hdr u_hdr (
        .ap_sel (ap_q),
        .addr   (addr_q),
        .hdr    (hdr)
    );

    swd_clk_gen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (clk_en),
        .half     (half_q),
        .swclk    (swclk),
        .rise_ev  (rise_ev),
        .slot_end (slot_end)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_REQ;
            S_REQ:  if (slot_end && idx == HDR_LAST) state_nx = S_TRN1;
            S_TRN1: if (slot_end) state_nx = S_ACK;
            S_ACK:  if (slot_end && idx == ACK_LAST)
                        state_nx = (ack_q == ACK_OK) ? S_TRN2 : S_FIN;
            S_TRN2: if (slot_end) state_nx = S_DATA;
            S_DATA: if (slot_end && idx == DATA_LAST) state_nx = S_PAR;
            S_PAR:  if (slot_end) state_nx = S_FIN;
            S_FIN:  state_nx = S_IDLE;
        endcase
    end

    // state register, slot index, captured request and acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            idx     <= '0;
            ap_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            half_q  <= '0;
            ack_q   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state)
                idx <= '0;
            else if (slot_end)
                idx <= idx + 1'b1;
            if (state == S_IDLE && start) begin
                ap_q    <= ap_sel;
                addr_q  <= addr;
                wdata_q <= wdata;
                half_q  <= half_div;
                ack_q   <= '0;
            end else if (state == S_ACK && rise_ev) begin
                ack_q[idx[1:0]] <= swdio_i;
            end
        end
    end

    // outputs
    always_comb begin
        swdio_o  = 1'b0;
        swdio_oe = 1'b0;
        clk_en   = 1'b0;
        unique case (state)
            S_IDLE, S_FIN: ;
            S_REQ: begin
                clk_en   = 1'b1;
                swdio_oe = 1'b1;
                swdio_o  = hdr[idx[2:0]];
            end
            S_TRN1, S_ACK, S_TRN2: clk_en = 1'b1;
            S_DATA: begin
                clk_en   = 1'b1;
                swdio_oe = 1'b1;
                swdio_o  = wdata_q[idx[$clog2(DATA_W)-1:0]];
            end
            S_PAR: begin
                clk_en   = 1'b1;
                swdio_oe = 1'b1;
                swdio_o  = ^wdata_q;
            end
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FIN);
    assign ack  = ack_q;

    // R5: pin frozen during the high half of a slot
    a_r5_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        (swclk && $past(swclk)) |-> ($stable(swdio_o) && $stable(swdio_oe)));

    // R4: no clock activity while idle
    a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !swclk);

    // R10: done lasts one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: data phase only after an OK acknowledge
    a_r9_data_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TRN2 || state == S_DATA || state == S_PAR) |-> (ack_q == ACK_OK));
endmodule

// File: tb/swd_wr_engine_tb.sv
module swd_wr_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ap_sel = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [7:0]  half_div = '0;
    logic        swclk, swdio_o, swdio_oe, busy, done;
    logic [2:0]  ack;
    logic        swdio_i;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    int rcnt    = 0;
    int base    = 0;
    logic [2:0] ack_drv = 3'b001;
    logic       prev_clk = 1'b0;
    logic       bit_o  [0:63];
    logic       bit_oe [0:63];
    int         rise_t [0:63];
    int         k;

    always #2 clk = ~clk;

    swd_wr_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ap_sel(ap_sel), .addr(addr),
        .wdata(wdata), .half_div(half_div), .swclk(swclk), .swdio_o(swdio_o),
        .swdio_oe(swdio_oe), .swdio_i(swdio_i), .busy(busy), .done(done), .ack(ack)
    );

    // target model: returns acknowledge bits in the three ack slots
    assign k = rcnt - base;
    assign swdio_i = (k >= 9 && k <= 11) ? ack_drv[k-9] : 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (swclk && !prev_clk) begin
            bit_o[rcnt % 64]  = swdio_o;
            bit_oe[rcnt % 64] = swdio_oe;
            rise_t[rcnt % 64] = cyc;
            rcnt = rcnt + 1;
        end
        prev_clk = swclk;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic ap, input logic [1:0] a, input logic [31:0] d,
                       input logic [7:0] h, input logic [2:0] av,
                       input bit mutate, input bit restrike);
        int t0, n, hh, nslots, wait_c;
        logic [7:0] hdr;
        @(negedge clk);
        ap_sel = ap; addr = a; wdata = d; half_div = h; ack_drv = av;
        base = rcnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = cyc;
        chk("R10", busy, 1, "busy after start");
        if (mutate) begin
            ap_sel = ~ap; addr = ~a; wdata = ~d; half_div = h + 8'd3;
        end
        wait_c = 0;
        while (!done && wait_c < 2000) begin
            @(negedge clk);
            wait_c++;
            if (restrike && wait_c == 40) start = 1'b1;
            if (restrike && wait_c == 41) start = 1'b0;
        end
        chk("R10", done, 1, "done reached");
        n = rcnt - base;
        hh = h + 1;
        nslots = (av == 3'b001) ? 46 : 12;
        chk((av == 3'b001) ? "R8" : "R9", n, nslots, "slot count");
        chk("R7", ack, av, "ack value");
        hdr = {1'b1, 1'b0, ap ^ a[0] ^ a[1], a[1], a[0], 1'b0, ap, 1'b1};
        for (int i = 0; i < 8; i++) begin
            chk(i == 5 ? "R3" : "R2", {bit_oe[(base+i)%64], bit_o[(base+i)%64]},
                {1'b1, hdr[i]}, "header bit");
        end
        for (int i = 8; i < 13 && i < nslots; i++)
            chk("R6", bit_oe[(base+i)%64], 0, "released slot");
        if (av == 3'b001) begin
            for (int i = 0; i < 32; i++)
                chk("R8", {bit_oe[(base+13+i)%64], bit_o[(base+13+i)%64]},
                    {1'b1, d[i]}, "data bit");
            chk("R8", {bit_oe[(base+45)%64], bit_o[(base+45)%64]}, {1'b1, ^d}, "data parity");
        end
        chk("R4", rise_t[base%64] - t0, hh, "first rise");
        for (int i = 1; i < nslots; i++)
            chk(mutate ? "R11" : "R4", rise_t[(base+i)%64] - rise_t[(base+i-1)%64], 2*hh, "slot period");
        @(negedge clk);
        chk("R10", {done, busy}, 0, "done single pulse");
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (swclk !== 1'b0 || swdio_oe !== 1'b0) begin
                chk("R9", {swclk, swdio_oe}, 0, "idle pins after end");
            end
        end
        chk(restrike ? "R10" : "R4", rcnt - base, nslots, "no extra clocking");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {swclk, swdio_oe, swdio_o, busy, done, ack}, 0, "reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {swclk, swdio_oe, swdio_o, busy, done, ack}, 0, "after reset release");
        // sweep port select, address and divider with an OK acknowledge
        for (int h = 0; h < 3; h++)
            for (int p = 0; p < 2; p++)
                for (int a = 0; a < 4; a++)
                    run(p[0], a[1:0], 32'hA5C3_0F01 ^ (32'h1111_1111 * (a + 4*p)) ^ h,
                        h[7:0], 3'b001, 1'b0, 1'b0);
        // the debug-port address-01 header with a zero word
        run(1'b0, 2'b01, 32'h0, 8'd0, 3'b001, 1'b0, 1'b0);
        run(1'b0, 2'b00, 32'hFFFF_FFFF, 8'd1, 3'b001, 1'b0, 1'b0);
        // every non-OK acknowledge code
        for (int v = 0; v < 8; v++)
            if (v != 1) run(v[0], v[1:0], 32'h1234_5678, 8'd1, v[2:0], 1'b0, 1'b0);
        // inputs changed mid-transaction and a start strobe while busy
        run(1'b1, 2'b10, 32'hDEAD_BEEF, 8'd2, 3'b001, 1'b1, 1'b0);
        run(1'b0, 2'b11, 32'h8000_0001, 8'd0, 3'b001, 1'b0, 1'b1);
        run(1'b1, 2'b01, 32'h0, 8'd1, 3'b100, 1'b1, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule